// File: doc/BRIEF.md
# Two-Thread Shared Branch Direction Predictor

This block guesses the direction of conditional branches for a core that runs two hardware threads and issues from both. All threads share one table of small saturating counters. Each thread keeps its own short register of recent branch outcomes. A lookup folds the thread's outcome history into the word-address bits of the fetch PC. This lets the same static branch train different counters for different recent paths, and each thread's path record stays free of the other thread's branches.

Fetch presents a thread id and a PC and gets a taken/not-taken guess in the same cycle. It also gets the history value that the guess used, and carries that value down the pipe. When the branch resolves, the back end returns the thread id, the PC, the real outcome and that saved history. The block then trains the addressed counter and appends the outcome to the thread's history register.

Table depth, history length, counter width, thread count and PC width are all parameters. The full-size configuration uses a 14-bit index, which gives 16384 two-bit counters (4 KB) and a 6-bit history per thread. The default here uses a 10-bit index so that elaboration stays small. Branch targets, return prediction and repair of speculative history are outside this block.

Top module: `sbp_shared_predictor`

## Requirements
- R1: After reset, every counter holds the value 1 (weakly not-taken), so every lookup predicts not-taken, and every thread's history reads zero.
- R2: `pred_taken` is the most significant bit of the addressed counter, so values 2 and 3 predict taken. It is combinational from `pred_tid` and `pred_pc` within the same cycle.
- R3: An update with `upd_taken`=1 raises the addressed counter by one and stops at 3. An update with `upd_taken`=0 lowers it by one and stops at 0. The new value is visible to lookups from the next cycle.
- R4: The table index is `pc[IDX_W+1:2]` XOR the history zero-extended to IDX_W bits, so history bit k lands on index bit k. A lookup uses the current history of `pred_tid`. An update uses the supplied `upd_hist`.
- R5: An update shifts the history of `upd_tid` left by one, with `upd_taken` entering bit 0 and the oldest bit dropped. The new value is visible from the next cycle.
- R6: An update leaves the history of every other thread unchanged. A cycle with `upd_valid`=0 changes no counter and no history.
- R7: When a lookup and an update address the same counter in the same cycle, the lookup returns the value from before the update.
- R8: `pred_hist` shows the current history register of `pred_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_tid | input | TID_W | Thread of the lookup |
| pred_pc | input | PC_W | Fetch PC of the lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used by this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_tid | input | TID_W | Thread of the resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_hist | input | HIST_W | History that was used when the branch was predicted |

## Verification
The bench first sweeps every table entry after reset. It then walks one counter up past 3 and down past 0. A counter that wraps instead of saturating flips its guess at those edges, and a wrong reset value shows up on the first sweep. Next it trains one thread while watching the other thread's history through `pred_hist`, which catches a shared or cross-written history register and a shift in the wrong direction. It also aims a lookup and an update at one entry in the same cycle, which catches a write-through path that leaks the new value early. A long interleaved two-thread trace with many index collisions, checked against an arithmetic model, catches history bits folded onto the wrong index bits and updates indexed with the live history instead of the saved one.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   localparam int unsigned SBP_PC_LSB      = 2;
   localparam int unsigned SBP_DEF_THREADS = 2;
   localparam int unsigned SBP_DEF_HIST_W  = 6;
   localparam int unsigned SBP_DEF_IDX_W   = 10;
   localparam int unsigned SBP_DEF_CNT_W   = 2;
   localparam int unsigned SBP_DEF_PC_W    = 32;

   function automatic int unsigned sbp_tid_bits(input int unsigned threads);
      return (threads > 1) ? $clog2(threads) : 1;
   endfunction
endpackage

// File: rtl/sbp_hash.sv
module sbp_hash #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned HIST_W = 6
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   import sbp_pkg::*;
   localparam int unsigned HI_BIT = IDX_W + SBP_PC_LSB;

   logic [IDX_W-1:0] hist_ext;
   logic             unused_pc_bits;

   generate
      if (HIST_W == IDX_W) begin : g_full_hist
         assign hist_ext = hist;
      end else begin : g_pad_hist
         assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
      end
   endgenerate

   assign idx = pc[HI_BIT-1:SBP_PC_LSB] ^ hist_ext;
   assign unused_pc_bits = ^{pc[PC_W-1:HI_BIT], pc[SBP_PC_LSB-1:0]};
endmodule

// File: rtl/sbp_hist_bank.sv
module sbp_hist_bank #(
   parameter int unsigned NUM_THR = 2,
   parameter int unsigned HIST_W  = 6,
   parameter int unsigned TID_W   = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_valid,
   input  logic [TID_W-1:0]          upd_tid,
   input  logic                      upd_taken,
   input  logic [TID_W-1:0]          rd_tid,
   output logic [HIST_W-1:0]         rd_hist,
   output logic [NUM_THR*HIST_W-1:0] hist_all
);
   logic [HIST_W-1:0] hist_q [NUM_THR];

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
         logic hit;
         assign hit = upd_valid && (upd_tid == TID_W'(t));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q[t] <= '0;
            end else if (hit) begin
               hist_q[t] <= {hist_q[t][HIST_W-2:0], upd_taken};
            end
         end
         assign hist_all[t*HIST_W +: HIST_W] = hist_q[t];
      end
   endgenerate

   assign rd_hist = hist_q[rd_tid];
endmodule

// File: rtl/sbp_ctr_table.sv
module sbp_ctr_table #(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned CNT_W    = 2,
   parameter int unsigned CNT_INIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int unsigned      DEPTH  = 1 << IDX_W;
   localparam logic [CNT_W-1:0] MAX_V  = '1;
   localparam logic [CNT_W-1:0] MIN_V  = '0;
   localparam logic [CNT_W-1:0] INIT_V = CNT_INIT[CNT_W-1:0];

   logic [CNT_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] cur_v;
   logic [CNT_W-1:0] nxt_v;

   assign cur_v = mem[wr_idx];

   always_comb begin
      nxt_v = cur_v;
      if (wr_up) begin
         if (cur_v != MAX_V) nxt_v = cur_v + 1'b1;
      end else begin
         if (cur_v != MIN_V) nxt_v = cur_v - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_V;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt_v;
      end
   end

   assign rd_cnt = mem[rd_idx];
endmodule

// File: rtl/sbp_shared_predictor.sv
module sbp_shared_predictor #(
   parameter int unsigned NUM_THR  = sbp_pkg::SBP_DEF_THREADS,
   parameter int unsigned HIST_W   = sbp_pkg::SBP_DEF_HIST_W,
   parameter int unsigned IDX_W    = sbp_pkg::SBP_DEF_IDX_W,
   parameter int unsigned CNT_W    = sbp_pkg::SBP_DEF_CNT_W,
   parameter int unsigned CNT_INIT = 1,
   parameter int unsigned PC_W     = sbp_pkg::SBP_DEF_PC_W,
   localparam int unsigned TID_W   = sbp_pkg::sbp_tid_bits(NUM_THR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TID_W-1:0]  pred_tid,
   input  logic [PC_W-1:0]   pred_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [TID_W-1:0]  upd_tid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [HIST_W-1:0] upd_hist
);
   initial begin
      assert (NUM_THR >= 1) else $error("NUM_THR must be at least 1");
      assert (HIST_W >= 2 && HIST_W <= IDX_W) else $error("HIST_W out of range");
      assert (PC_W >= IDX_W + 3) else $error("PC_W too narrow for IDX_W");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
      assert (CNT_INIT < (1 << CNT_W)) else $error("CNT_INIT exceeds counter range");
   end

   logic [NUM_THR*HIST_W-1:0] hist_all;
   logic [IDX_W-1:0]          pred_idx;
   logic [IDX_W-1:0]          upd_idx;
   logic [CNT_W-1:0]          pred_cnt;

   sbp_hist_bank #(.NUM_THR(NUM_THR), .HIST_W(HIST_W), .TID_W(TID_W)) i_hist (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_taken(upd_taken),
      .rd_tid(pred_tid), .rd_hist(pred_hist), .hist_all(hist_all)
   );

   sbp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_hash_pred (
      .pc(pred_pc), .hist(pred_hist), .idx(pred_idx)
   );

   sbp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_hash_upd (
      .pc(upd_pc), .hist(upd_hist), .idx(upd_idx)
   );

   sbp_ctr_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) i_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pred_idx), .rd_cnt(pred_cnt),
      .wr_en(upd_valid), .wr_idx(upd_idx), .wr_up(upd_taken)
   );

   assign pred_taken = pred_cnt[CNT_W-1];
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
   parameter int unsigned NUM_THR = 2,
   parameter int unsigned HIST_W  = 6,
   parameter int unsigned TID_W   = 1,
   parameter int unsigned PC_W    = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [TID_W-1:0]          pred_tid,
   input logic [PC_W-1:0]           pred_pc,
   input logic                      pred_taken,
   input logic                      upd_valid,
   input logic [TID_W-1:0]          upd_tid,
   input logic                      upd_taken,
   input logic [NUM_THR*HIST_W-1:0] hist_all
);
   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
         // R5: the updating thread shifts its outcome into bit 0
         p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && upd_tid == TID_W'(t)) |=>
               hist_all[t*HIST_W +: HIST_W] ==
               {$past(hist_all[t*HIST_W +: HIST_W-1]), $past(upd_taken)});
         // R6: no update for this thread leaves its history alone
         p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(upd_valid && upd_tid == TID_W'(t)) |=>
               $stable(hist_all[t*HIST_W +: HIST_W]));
      end
   endgenerate

   // R6: without an update, a repeated lookup repeats its answer
   p_pred_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(pred_pc) && $stable(pred_tid) && !$past(upd_valid)) |->
         $stable(pred_taken));

   // R4: update thread must name an existing history register
   p_upd_tid_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (int'(upd_tid) < NUM_THR));
endmodule

bind sbp_shared_predictor sbp_checker #(
   .NUM_THR(NUM_THR), .HIST_W(HIST_W), .TID_W(TID_W), .PC_W(PC_W)
) i_sbp_chk (
   .clk(clk), .rst_n(rst_n), .pred_tid(pred_tid), .pred_pc(pred_pc),
   .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_tid(upd_tid),
   .upd_taken(upd_taken), .hist_all(hist_all)
);

// File: tb/test_sbp_shared_predictor.sv
`timescale 1ns/1ps
module test_sbp_shared_predictor;
   localparam int IDX_W = 10;
   localparam int DEPTH = 1 << IDX_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_tid = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic [5:0]  pred_hist;
   logic        upd_valid = 1'b0;
   logic        upd_tid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [5:0]  upd_hist = '0;

   int n_run = 0;
   int n_fail = 0;
   int mcnt [DEPTH];
   logic [5:0] mhist [2];

   always #2.5 clk = ~clk;

   sbp_shared_predictor i_sbp_shared_predictor (
      .clk(clk), .rst_n(rst_n), .pred_tid(pred_tid), .pred_pc(pred_pc),
      .pred_taken(pred_taken), .pred_hist(pred_hist), .upd_valid(upd_valid),
      .upd_tid(upd_tid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
   );

   function automatic int midx(input logic [31:0] pc, input logic [5:0] h);
      return int'((pc >> 2) & (DEPTH - 1)) ^ int'(h);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: lookup checked before the edge, then optional update
   task automatic step(input string req, input logic ptid, input logic [31:0] ppc,
                       input logic uv, input logic utid, input logic [31:0] upc,
                       input logic utk, input logic [5:0] uh);
      int e;
      @(negedge clk);
      pred_tid = ptid; pred_pc = ppc;
      upd_valid = uv; upd_tid = utid; upd_pc = upc; upd_taken = utk; upd_hist = uh;
      #1;
      e = midx(ppc, mhist[ptid]);
      chk({req, " pred_taken"}, int'(pred_taken), (mcnt[e] >= 2) ? 1 : 0);
      chk({req, " pred_hist"}, int'(pred_hist), int'(mhist[ptid]));
      @(posedge clk);
      if (uv) begin
         e = midx(upc, uh);
         if (utk) begin
            if (mcnt[e] < 3) mcnt[e]++;
         end else begin
            if (mcnt[e] > 0) mcnt[e]--;
         end
         mhist[utid] = {mhist[utid][4:0], utk};
      end
   endtask

   task automatic look(input string req, input logic ptid, input logic [31:0] ppc);
      step(req, ptid, ppc, 1'b0, 1'b0, 32'h0, 1'b0, 6'h0);
   endtask

   initial begin
      #(200000 * 5);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mcnt[i] = 1;
      mhist[0] = '0; mhist[1] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: every entry weakly not-taken, histories zero
      for (int i = 0; i < DEPTH; i++) look("R1 reset sweep", 1'b0, 32'(i) << 2);
      look("R1 thread1 history", 1'b1, 32'h40);

      // R3 and R2: walk counter at pc 0x100 up past saturation (train via thread 1, hist 0)
      for (int k = 0; k < 4; k++) begin
         step("R3 train up", 1'b0, 32'h100, 1'b1, 1'b1, 32'h100, 1'b1, 6'h0);
         look("R2 after up", 1'b0, 32'h100);
      end
      for (int k = 0; k < 5; k++) begin
         step("R3 train down", 1'b0, 32'h100, 1'b1, 1'b1, 32'h100, 1'b0, 6'h0);
         look("R2 after down", 1'b0, 32'h100);
      end
      step("R3 leave zero", 1'b0, 32'h100, 1'b1, 1'b1, 32'h100, 1'b1, 6'h0);
      look("R3 floor", 1'b0, 32'h100);

      // R5 and R6: thread 0 history fills, thread 1 watched for isolation
      step("R5 shift", 1'b1, 32'h0, 1'b1, 1'b0, 32'h200, 1'b1, 6'h0);
      step("R5 shift", 1'b0, 32'h0, 1'b1, 1'b0, 32'h204, 1'b0, 6'h0);
      step("R5 shift", 1'b1, 32'h0, 1'b1, 1'b0, 32'h208, 1'b1, 6'h0);
      step("R5 shift", 1'b0, 32'h0, 1'b1, 1'b0, 32'h20c, 1'b1, 6'h0);
      look("R8 thread0 history", 1'b0, 32'h0);
      chk("R5 thread0 value", int'(pred_hist), 6'b001011);
      look("R6 thread1 isolated", 1'b1, 32'h0);
      look("R6 idle cycle", 1'b0, 32'h0);

      // R4: train with thread 0's history and look up through it
      for (int k = 0; k < 2; k++)
         step("R4 hashed train", 1'b1, 32'h300, 1'b1, 1'b1, 32'h300, 1'b1, mhist[0]);
      look("R4 hashed hit", 1'b0, 32'h300);
      look("R4 alias pc", 1'b1, 32'h300 ^ (32'(mhist[0]) << 2));

      // R7: lookup and update on the same counter in one cycle
      step("R7 same entry", 1'b1, 32'h500, 1'b1, 1'b0, 32'h500, 1'b1, mhist[1]);
      step("R7 same entry", 1'b1, 32'h500, 1'b1, 1'b0, 32'h500, 1'b1, mhist[1]);
      look("R7 after", 1'b1, 32'h500);

      // interleaved two-thread trace with dense collisions
      for (int k = 0; k < 6000; k++) begin
         logic pt, ut, uv, tk;
         logic [31:0] ppc, upc;
         logic [5:0] uh;
         pt  = 1'($urandom_range(0, 1));
         ut  = 1'($urandom_range(0, 1));
         uv  = ($urandom_range(0, 3) != 0);
         tk  = 1'($urandom_range(0, 1));
         ppc = {$urandom, 2'b00} & 32'hffff_00fc;
         upc = ($urandom_range(0, 3) == 0) ? ppc : ({$urandom, 2'b00} & 32'hffff_00fc);
         uh  = ($urandom_range(0, 2) == 0) ? 6'($urandom) : mhist[ut];
         step("R4 R5 R7 trace", pt, ppc, uv, ut, upc, tk, uh);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule